// File: doc/BRIEF.md
# PCI Special-Cycle Message Receiver

This block is a passive listener on a conventional parallel PCI bus. It watches the framing, initiator-ready, command/byte-enable and address/data lines. It picks out transactions whose command is the broadcast special-cycle command. From the first completed data phase of such a transaction it keeps the 16-bit message and the 16-bit optional data word. It then raises a one-cycle strobe, so that local logic can act on the broadcast.

A special cycle is addressed to no agent, so the receiver never claims it. The block has no target-response outputs of any kind. It only observes the bus.

Two message codes carry a fixed meaning here: a shutdown request and a halt request. The block turns each of them into an event pulse. A local enable mask gates these pulses, because each agent decides for itself whether a broadcast concerns it. Every other code, the architecture-specific one and the reserved range included, is still reported through the strobe, the code and the data outputs. Such a code raises no event.

Top module: `sc_msg_rx`

## Requirements
- R1: After a synchronous active-high reset, `msg_vld`, `shutdown_evt` and `halt_evt` are 0, and `msg_code` and `msg_data` are 0.
- R2: A transaction is taken as a special cycle only when `cbe_n` equals 4'b0001 on the address-phase clock, which is the first clock with `frame_n` low after an idle bus. Any other command value gives no `msg_vld`, no event, and no change of `msg_code`/`msg_data`.
- R3: The value on `ad` during the address phase has no effect on any output.
- R4: Capture happens on the first rising edge of the data phase at which `irdy_n` is low. Wait states with `irdy_n` high capture nothing. `msg_code` takes `ad[15:0]` and `msg_data` takes `ad[31:16]`, and both hold until the next capture.
- R5: `msg_vld` is high for exactly one cycle, the cycle right after the capture edge.
- R6: Message code 0x0000 raises `shutdown_evt` in the same cycle as `msg_vld` when `evt_en[0]` is 1.
- R7: Message code 0x0001 raises `halt_evt` in the same cycle as `msg_vld` when `evt_en[1]` is 1.
- R8: Code 0x0002 and every code from 0x0003 to 0xFFFF raise neither event, but they still give `msg_vld`, `msg_code` and `msg_data`.
- R9: When the enable bit for a decoded message is 0, its event stays low while `msg_vld` is still raised. `evt_en` is sampled at the capture edge.
- R10: Data phases after the first one in a special cycle are not captured. The receiver recognises no new transaction until `frame_n` and `irdy_n` have both been high at a clock edge. After that it accepts the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Bus framing signal, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase) |
| ad | input | 32 | Multiplexed address/data lines |
| evt_en | input | 2 | Event enable mask: bit 0 shutdown, bit 1 halt |
| msg_vld | output | 1 | One-cycle strobe after a message is captured |
| msg_code | output | 16 | Captured message code |
| msg_data | output | 16 | Captured optional data word |
| shutdown_evt | output | 1 | Shutdown event pulse |
| halt_evt | output | 1 | Halt event pulse |

## Verification
The bench sweeps message codes 0, 1, 2, the bottom and top of the reserved range and a mid-range value, each against all four enable masks. This separates correct decoding from mask gating and from events leaking on other codes. Every one of the fifteen other command values is then sent with a zero message, decoy address bits and special-cycle-like byte enables during the data phase, which tells command recognition apart from data-phase pattern matching. Wait states of different lengths and two-phase bursts show whether capture happens on the first ready data phase only, and back-to-back transactions show whether the receiver returns to idle.

// File: rtl/sc_msg_pkg.sv
package sc_msg_pkg;

    localparam int AD_W     = 32;
    localparam int HALF_W   = AD_W / 2;
    localparam int CBE_W    = 4;
    localparam int N_EVT    = 2;

    localparam logic [CBE_W-1:0]  CMD_SPECIAL   = 4'b0001;
    localparam logic [HALF_W-1:0] CODE_SHUTDOWN = 16'h0000;
    localparam logic [HALF_W-1:0] CODE_HALT     = 16'h0001;

    localparam int EVT_SHUTDOWN = 0;
    localparam int EVT_HALT     = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] code;
    } msg_t;

    function automatic logic [N_EVT-1:0] decode_msg(input logic [HALF_W-1:0] code);
        logic [N_EVT-1:0] hit;
        hit               = '0;
        hit[EVT_SHUTDOWN] = (code == CODE_SHUTDOWN);
        hit[EVT_HALT]     = (code == CODE_HALT);
        return hit;
    endfunction

endpackage

// File: rtl/sc_phase_track.sv
module sc_phase_track
    import sc_msg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [CBE_W-1:0] cbe_n,
    output logic             capture
);

    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (!frame_n) begin
                    state_d = (cbe_n == CMD_SPECIAL) ? PH_DATA : PH_HOLD;
                end
            end
            PH_DATA: begin
                if (!irdy_n) begin
                    capture = 1'b1;
                    state_d = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (frame_n && irdy_n) begin
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/sc_msg_latch.sv
module sc_msg_latch
    import sc_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [AD_W-1:0]   ad,
    input  logic [N_EVT-1:0]  evt_en,
    output msg_t              msg,
    output logic              vld,
    output logic [N_EVT-1:0]  evt
);

    msg_t             msg_q;
    logic             vld_q;
    logic [N_EVT-1:0] evt_q;
    logic [N_EVT-1:0] hit;

    assign hit = decode_msg(ad[HALF_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            vld_q <= 1'b0;
            evt_q <= '0;
        end else begin
            vld_q <= capture;
            evt_q <= '0;
            if (capture) begin
                msg_q.code <= ad[HALF_W-1:0];
                msg_q.data <= ad[AD_W-1:HALF_W];
                evt_q      <= hit & evt_en;
            end
        end
    end

    assign msg = msg_q;
    assign vld = vld_q;
    assign evt = evt_q;

endmodule

// File: rtl/sc_msg_rx.sv
module sc_msg_rx
    import sc_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [CBE_W-1:0]  cbe_n,
    input  logic [AD_W-1:0]   ad,
    input  logic [N_EVT-1:0]  evt_en,
    output logic              msg_vld,
    output logic [HALF_W-1:0] msg_code,
    output logic [HALF_W-1:0] msg_data,
    output logic              shutdown_evt,
    output logic              halt_evt
);

    logic             capture;
    msg_t             msg;
    logic [N_EVT-1:0] evt;

    sc_phase_track u_track (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .cbe_n   (cbe_n),
        .capture (capture)
    );

    sc_msg_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .ad      (ad),
        .evt_en  (evt_en),
        .msg     (msg),
        .vld     (msg_vld),
        .evt     (evt)
    );

    assign msg_code     = msg.code;
    assign msg_data     = msg.data;
    assign shutdown_evt = evt[EVT_SHUTDOWN];
    assign halt_evt     = evt[EVT_HALT];

endmodule

// File: rtl/sc_msg_rx_chk.sv
module sc_msg_rx_chk
    import sc_msg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irdy_n,
    input logic [N_EVT-1:0]  evt_en,
    input logic              msg_vld,
    input logic [HALF_W-1:0] msg_code,
    input logic [HALF_W-1:0] msg_data,
    input logic              shutdown_evt,
    input logic              halt_evt
);

    // R5: the strobe never lasts two cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        msg_vld |=> !msg_vld);

    // R4: a capture needs initiator ready on the preceding edge
    p_capture_on_ready_r4: assert property (@(posedge clk) disable iff (rst)
        msg_vld |-> $past(!irdy_n));

    // R4: code and data only move together with the strobe
    p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
        !msg_vld |-> ($stable(msg_code) && $stable(msg_data)));

    // R6: shutdown only with its code, its enable and the strobe
    p_shutdown_code_r6: assert property (@(posedge clk) disable iff (rst)
        shutdown_evt |-> (msg_vld && msg_code == CODE_SHUTDOWN && $past(evt_en[EVT_SHUTDOWN])));

    // R7: halt only with its code, its enable and the strobe
    p_halt_code_r7: assert property (@(posedge clk) disable iff (rst)
        halt_evt |-> (msg_vld && msg_code == CODE_HALT && $past(evt_en[EVT_HALT])));

    // R8: never both events at once
    p_events_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(shutdown_evt && halt_evt));

endmodule

bind sc_msg_rx sc_msg_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .irdy_n       (irdy_n),
    .evt_en       (evt_en),
    .msg_vld      (msg_vld),
    .msg_code     (msg_code),
    .msg_data     (msg_data),
    .shutdown_evt (shutdown_evt),
    .halt_evt     (halt_evt)
);

// File: tb/tb_sc_msg_rx.sv
`timescale 1ns/1ps
module tb_sc_msg_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad = '0;
    logic [1:0]  evt_en = 2'b00;
    logic        msg_vld;
    logic [15:0] msg_code;
    logic [15:0] msg_data;
    logic        shutdown_evt;
    logic        halt_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_code = 16'h0;
    logic [15:0] exp_data = 16'h0;

    always #5 clk = ~clk;

    sc_msg_rx dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad(ad), .evt_en(evt_en), .msg_vld(msg_vld),
        .msg_code(msg_code), .msg_data(msg_data),
        .shutdown_evt(shutdown_evt), .halt_evt(halt_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_quiet(input string req);
        check({req, " msg_vld"}, {31'b0, msg_vld}, 32'd0);
        check({req, " shutdown"}, {31'b0, shutdown_evt}, 32'd0);
        check({req, " halt"}, {31'b0, halt_evt}, 32'd0);
        check({req, " code"}, {16'b0, msg_code}, {16'b0, exp_code});
        check({req, " data"}, {16'b0, msg_data}, {16'b0, exp_data});
    endtask

    // One transaction: address phase, waits, first data phase, optional second phase, idle
    task automatic run_tx(input logic [3:0] cmd, input logic [31:0] addr,
                          input logic [31:0] d0, input logic [31:0] d1,
                          input int waits, input bit two, input logic [1:0] en);
        bit special;
        special = (cmd == 4'b0001);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad = addr; evt_en = en;
        @(negedge clk);
        // R3: address-phase AD must not show up anywhere
        check_quiet("R3");
        cbe_n = 4'b0001; ad = d0;
        for (int w = 0; w < waits; w++) begin
            irdy_n = 1'b1;
            @(negedge clk);
            check_quiet("R4 wait");
        end
        irdy_n = 1'b0;
        frame_n = two ? 1'b0 : 1'b1;
        @(negedge clk);
        if (special) begin
            exp_code = d0[15:0];
            exp_data = d0[31:16];
            check("R5 vld", {31'b0, msg_vld}, 32'd1);
            check("R4 code", {16'b0, msg_code}, {16'b0, exp_code});
            check("R4 data", {16'b0, msg_data}, {16'b0, exp_data});
            check("R6 shutdown", {31'b0, shutdown_evt},
                  {31'b0, (d0[15:0] == 16'h0000) && en[0]});
            check("R7 halt", {31'b0, halt_evt},
                  {31'b0, (d0[15:0] == 16'h0001) && en[1]});
        end else begin
            check_quiet("R2");
        end
        if (two) begin
            ad = d1; irdy_n = 1'b0; frame_n = 1'b1;
            @(negedge clk);
            check_quiet("R10 second phase");
        end
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = 32'hDEAD_BEEF;
        @(negedge clk);
        check_quiet("R5 after");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] codes [6];
        codes[0] = 16'h0000; codes[1] = 16'h0001; codes[2] = 16'h0002;
        codes[3] = 16'h0003; codes[4] = 16'h8000; codes[5] = 16'hFFFF;

        repeat (3) @(negedge clk);
        // R1: reset state
        check_quiet("R1");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R1 post");

        // R6 R7 R8 R9: sweep codes against every mask, varying waits
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 6; c++) begin
                run_tx(4'b0001, {16'hFFFF, 16'h0001} ^ {28'b0, m[1:0], 2'b0},
                       {c[7:0], m[7:0], codes[c]}, 32'h0,
                       (c + m) % 3, 1'b0, m[1:0]);
            end
        end

        // R2 R10: every other command, with decoy data phases
        for (int k = 0; k < 16; k++) begin
            if (k != 1) begin
                run_tx(k[3:0], 32'h0000_0001, 32'h1234_0000, 32'h0000_0001,
                       k % 2, 1'b1, 2'b11);
            end
        end

        // R10: two-phase special cycle keeps only the first message
        run_tx(4'b0001, 32'h0, 32'hA5A5_0002, 32'h0000_0000, 0, 1'b1, 2'b11);
        run_tx(4'b0001, 32'h0, 32'h0101_0001, 32'h0000_0000, 2, 1'b1, 2'b11);

        // R10: back-to-back special cycles after one idle clock
        run_tx(4'b0001, 32'hFFFF_FFFF, 32'h7777_0000, 32'h0, 0, 1'b0, 2'b01);
        run_tx(4'b0001, 32'h0000_0000, 32'h6666_0001, 32'h0, 0, 1'b0, 2'b10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule